// File: doc/BRIEF.md
# Display Row Readout Mapper

During display scanning, this block tells the display memory which stored row to fetch for the row driver that is active now. It takes the scan row counter, a multiplex ratio selection, a scroll offset, a row mirror control, an icon mode control and the Y carriage value. It returns a bank number and a bit position inside that bank, plus a flag that marks the icon row.

The mirror and scroll controls change only how rows are read out. The memory contents are never altered.

When icon mode is set, the icon line stays on the last active driver and is read from a fixed bank. That bank depends on the multiplex ratio and on the Y carriage value. All other drivers scroll and mirror over the graphic lines only. When icon mode is clear, the icon line joins the graphic lines and scrolls and mirrors with them. The mapping is combinational, and a single register stage on the output meets the fetch timing.

Top module: `row_readout_map`

## Requirements
- R1: The multiplex ratio select is decoded as follows. `mux_sel` = 0 gives 33 active drivers, 1 gives 49, and 2 or 3 gives 65. Drivers 0 to M-2 are graphic drivers, where M is the active count. Driver M-1 is the icon driver.
- R2: Outputs are registered and reflect the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are zero.
- R3: The icon bank is B = max(min(`ycar`, 8), M/8), so 4, 6 or 8 when the carriage does not exceed that value. With `icon_mode` = 1, the icon driver reads bank B, bit 0, with `icon_row` = 1, whatever the values of `scroll` and `mirror`.
- R4: The number of graphic lines is N = 8·B. With `icon_mode` = 1 and no mirror, graphic driver d reads line (d + `scroll`) mod N.
- R5: With `icon_mode` = 1 and `mirror` = 1, graphic driver d first becomes (M-2-d), and the scroll and wrap of R4 are then applied.
- R6: With `icon_mode` = 0, drivers 0 to M-1 all take part. The driver index is (M-1-d) when mirrored, and d otherwise. The line read is (index + `scroll`) mod (N+1). `icon_row` is 1 exactly when that line equals N.
- R7: Line L is presented as `row_bank` = L/8 and `row_bit` = L mod 8.
- R8: A scan row of M or more reads bank 0, bit 0, with `icon_row` = 0.
- R9: With `icon_mode` = 1, a graphic driver never reads the icon line and never raises `icon_row`. `row_bank` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_row | input | 7 | Row driver index being scanned |
| mux_sel | input | 2 | Multiplex ratio select (0:33, 1:49, 2/3:65) |
| scroll | input | 7 | Scroll offset in lines |
| mirror | input | 1 | Reverse the order of the driven rows |
| icon_mode | input | 1 | Exempt the icon line from scroll and mirror |
| ycar | input | 4 | Y carriage value, in banks |
| row_bank | output | 4 | Memory bank to fetch |
| row_bit | output | 3 | Bit position within the bank |
| icon_row | output | 1 | The fetched line is the icon line |

## Verification
Mirroring and the scroll wrap can act on the same driver in the same cycle. This is provoked by setting `mirror` together with a scroll offset that pushes the reversed index past the graphic line count, at all three ratios and with carriage values below, equal to and above M/8. The bench drives one setting per clock. One edge later it compares bank, bit and flag with a model written from R4 to R6. It watches in particular the icon driver and its neighbour, where the icon exemption also acts in that cycle. With icon mode clear, the same pattern checks that the wrap lands on the icon line exactly once per period.

// File: rtl/row_readout_map.sv
module row_readout_map #(
  parameter int ROW_W  = 7,
  parameter int BANK_W = 4,
  parameter int BIT_W  = 3,
  parameter int TOP_BANK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic [1:0]        mux_sel,
  input  logic [ROW_W-1:0]  scroll,
  input  logic              mirror,
  input  logic              icon_mode,
  input  logic [BANK_W-1:0] ycar,
  output logic [BANK_W-1:0] row_bank,
  output logic [BIT_W-1:0]  row_bit,
  output logic              icon_row
);

  localparam int W = ROW_W + 1;

  logic [W-1:0]      mux_rows;
  logic [BANK_W-1:0] base_bank, yc, icon_bank;
  logic [W-1:0]      nlines, span, drivers, idx, sc, sum;
  logic [W-1:0]      line_n;
  logic              flag_n;
  logic              primed;

  always_comb begin
    case (mux_sel)
      2'd0:    begin mux_rows = W'(33); base_bank = BANK_W'(4); end
      2'd1:    begin mux_rows = W'(49); base_bank = BANK_W'(6); end
      default: begin mux_rows = W'(65); base_bank = BANK_W'(TOP_BANK); end
    endcase
  end

  assign yc        = (ycar > BANK_W'(TOP_BANK)) ? BANK_W'(TOP_BANK) : ycar;
  assign icon_bank = (yc > base_bank) ? yc : base_bank;
  assign nlines    = W'({icon_bank, 3'b000});
  assign span      = icon_mode ? nlines : nlines + W'(1);
  assign drivers   = icon_mode ? mux_rows - W'(1) : mux_rows;

  always_comb begin
    idx = mirror ? drivers - W'(1) - W'(scan_row) : W'(scan_row);
    sc  = W'(scroll);
    for (int k = 0; k < 3; k++)
      if (sc >= span) sc = sc - span;
    sum = idx + sc;
    if (sum >= span) sum = sum - span;
  end

  always_comb begin
    if (W'(scan_row) >= mux_rows) begin
      line_n = '0;
      flag_n = 1'b0;
    end else if (icon_mode && W'(scan_row) == mux_rows - W'(1)) begin
      line_n = nlines;
      flag_n = 1'b1;
    end else begin
      line_n = sum;
      flag_n = (sum == nlines);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_bank <= '0;
      row_bit  <= '0;
      icon_row <= 1'b0;
      primed   <= 1'b0;
    end else begin
      row_bank <= BANK_W'(line_n[W-1:3]);
      row_bit  <= line_n[2:0];
      icon_row <= flag_n;
      primed   <= 1'b1;
    end
  end

  AST_BANK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    row_bank <= BANK_W'(TOP_BANK)); // R9

  AST_ICON_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    icon_row |-> (row_bit == '0 && row_bank >= BANK_W'(4))); // R3

  AST_ICON_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(icon_mode) && W'($past(scan_row)) == $past(mux_rows) - W'(1))
      |-> (icon_row && row_bit == '0)); // R3

  AST_GRAPHIC_NO_ICON: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(icon_mode) && W'($past(scan_row)) < $past(mux_rows) - W'(1))
      |-> !icon_row); // R9

  AST_IDLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && W'($past(scan_row)) >= $past(mux_rows))
      |-> (row_bank == '0 && row_bit == '0 && !icon_row)); // R8

  AST_REG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $stable(scan_row) && $stable(mux_sel) && $stable(scroll) &&
     $stable(mirror) && $stable(icon_mode) && $stable(ycar) && $past(primed))
      |=> ($stable(row_bank) && $stable(row_bit) && $stable(icon_row))); // R2

endmodule

// File: tb/test_row_readout_map.sv
module test_row_readout_map;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] scan_row = '0;
  logic [1:0] mux_sel = '0;
  logic [6:0] scroll = '0;
  logic       mirror = 1'b0;
  logic       icon_mode = 1'b1;
  logic [3:0] ycar = '0;
  logic [3:0] row_bank;
  logic [2:0] row_bit;
  logic       icon_row;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  row_readout_map i_row_readout_map (
    .clk(clk), .rst_n(rst_n), .scan_row(scan_row), .mux_sel(mux_sel),
    .scroll(scroll), .mirror(mirror), .icon_mode(icon_mode), .ycar(ycar),
    .row_bank(row_bank), .row_bit(row_bit), .icon_row(icon_row));

  function automatic logic [7:0] model(int ms, int sr, int sc, bit mi, bit im, int y);
    int m, g, b, n, l, p, md, r;
    m = (ms == 0) ? 33 : (ms == 1) ? 49 : 65;
    g = m - 1;
    if (y > 8) y = 8;
    b = (y > m / 8) ? y : m / 8;
    n = 8 * b;
    if (sr >= m) return 8'h00;
    if (im && sr == g) return {1'b1, 4'(b), 3'd0};
    l = im ? n : n + 1;
    p = im ? g : m;
    md = mi ? p - 1 - sr : sr;
    r = (md + sc) % l;
    return {(r == n), 4'(r / 8), 3'(r % 8)};
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    logic [7:0] act;
    act = {icon_row, row_bank, row_bit};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got icon=%0d bank=%0d bit=%0d, expected icon=%0d bank=%0d bit=%0d",
               tag, act[7], act[6:3], act[2:0], exp[7], exp[6:3], exp[2:0]);
    end
  endtask

  task automatic apply(int ms, int sr, int sc, bit mi, bit im, int y);
    @(negedge clk);
    mux_sel = 2'(ms); scan_row = 7'(sr); scroll = 7'(sc);
    mirror = mi; icon_mode = im; ycar = 4'(y);
    @(negedge clk);
  endtask

  task automatic vec(string tag, int ms, int sr, int sc, bit mi, bit im, int y);
    apply(ms, sr, sc, mi, im, y);
    check(tag, model(ms, sr, sc, mi, im, y));
  endtask

  task automatic t_reset;
    @(negedge clk);
    scan_row = 7'd32; icon_mode = 1'b1;
    @(negedge clk);
    check("R2 reset", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 first load", {1'b1, 4'd4, 3'd0});
  endtask

  task automatic t_ratio;
    vec("R1 mux33 icon", 0, 32, 0, 0, 1, 0);
    vec("R1 mux49 icon", 1, 48, 0, 0, 1, 0);
    vec("R1 mux65 icon", 2, 64, 0, 0, 1, 0);
    vec("R1 sel3 icon", 3, 64, 0, 0, 1, 0);
    apply(1, 48, 0, 0, 1, 0);
    check("R1 explicit bank6", {1'b1, 4'd6, 3'd0});
  endtask

  task automatic t_plain_scroll;
    apply(2, 5, 0, 0, 1, 8);
    check("R7 line5", {1'b0, 4'd0, 3'd5});
    apply(2, 60, 10, 0, 1, 8);
    check("R4 wrap 70->6", {1'b0, 4'd0, 3'd6});
    for (int d = 0; d < 64; d += 7) vec("R4 sweep", 2, d, 37, 0, 1, 3);
  endtask

  task automatic t_mirror;
    apply(0, 0, 0, 1, 1, 0);
    check("R5 mirror top", {1'b0, 4'd3, 3'd7});
    apply(0, 31, 0, 1, 1, 0);
    check("R5 mirror bottom", {1'b0, 4'd0, 3'd0});
    for (int d = 0; d < 48; d += 5) vec("R5 mirror+wrap", 1, d, 45, 1, 1, 2);
  endtask

  task automatic t_icon_exempt;
    apply(1, 48, 20, 1, 1, 2);
    check("R3 icon ignores scroll/mirror", {1'b1, 4'd6, 3'd0});
    apply(0, 32, 0, 0, 1, 7);
    check("R3 icon at carriage 7", {1'b1, 4'd7, 3'd0});
    apply(0, 31, 30, 0, 1, 7);
    check("R4 carriage 7 wrap 61->5", {1'b0, 4'd0, 3'd5});
    apply(0, 32, 5, 0, 1, 12);
    check("R3 carriage clamp", {1'b1, 4'd8, 3'd0});
    for (int d = 0; d < 32; d++) vec("R9 graphic never icon", 0, d, 31, d[0], 1, 0);
  endtask

  task automatic t_icon_off;
    apply(0, 32, 0, 0, 0, 4);
    check("R6 icon as line32", {1'b1, 4'd4, 3'd0});
    apply(0, 32, 1, 0, 0, 4);
    check("R6 wrap to 0", {1'b0, 4'd0, 3'd0});
    apply(0, 31, 1, 0, 0, 4);
    check("R6 reaches icon", {1'b1, 4'd4, 3'd0});
    apply(0, 0, 0, 1, 0, 4);
    check("R6 mirror puts icon first", {1'b1, 4'd4, 3'd0});
    for (int d = 0; d < 65; d += 4) vec("R6 sweep", 2, d, 99, d[1], 0, 5);
  endtask

  task automatic t_idle;
    apply(0, 40, 9, 1, 1, 0);
    check("R8 unused driver", 8'h00);
    apply(1, 49, 3, 0, 0, 6);
    check("R8 first unused", 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ratio();
        t_plain_scroll();
        t_mirror();
        t_icon_exempt();
        t_icon_off();
        t_idle();
        done = 1'b1;
      end
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          n_vec++; n_bad++;
          $display("FAIL watchdog: got hang, expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule